// File: doc/BRIEF.md
# Ethernet Pause Frame Transmit Controller

This block drives the transmit half of full-duplex MAC flow control. It holds a small configuration register: a pause time, a two-bit resend threshold select, a disable for zero-quanta pauses, a transmit flow-control enable and an initiate bit that also serves as a busy flag. It decides when a pause frame must go out and what pause value it carries. It presents one request at a time to a frame transmitter and waits for that transmitter's done pulse.

Pause frames can come from four sources. Software can start one through the initiate bit. The external flow-control request starts one on its rising edge. While that request stays high, the block sends a refresh as the last pause nears its end. The block measures this with slot-time ticks counted after the previous frame completed. When the request falls, the block sends a zero-value pause that releases the link partner. In half-duplex mode the block sends no frames. It drives a backpressure level instead.

Top module: `pause_tx_ctrl`

## Requirements
- R1: After reset all register fields read 0, and `pause_req` and `backpressure` are low.
- R2: A write loads all five fields, which read back on the `reg_*` outputs from the next cycle. Writes are always taken in half-duplex mode, and in full-duplex mode whenever `reg_busy` is low.
- R3: In full-duplex mode a write that arrives while `reg_busy` is high changes no field.
- R4: A write with the initiate bit set makes `reg_busy` high in the next cycle. `pause_req` rises one cycle later with `pause_val` equal to the pause time. Once the frame completes, `pause_req` and `reg_busy` are both low in the cycle after `pause_done`.
- R5: No pause request is raised in half-duplex mode, or while the flow enable is 0. If the initiate bit is set in full-duplex mode with the enable at 0, `reg_busy` clears one cycle later.
- R6: In full-duplex mode with the enable set, a rising edge of `fc_req` raises `pause_req` two cycles later, with `pause_val` equal to the pause time.
- R7: Once a nonzero pause frame completes, a counter of `slot_tick` pulses starts from 0. When the count plus an offset reaches the pause time, and `fc_req` is still high, a new frame carrying the pause time is requested two cycles later. The threshold select chooses the offset: 0 gives 4 slots, 1 gives 28, 2 gives 144 and 3 gives 256. If the offset is not smaller than the pause time, the resend follows at once.
- R8: A falling edge of `fc_req` in full-duplex mode with the enable set raises a request with `pause_val` = 0 two cycles later. No such request is raised when the zero-quanta disable bit is 1.
- R9: Only one request is outstanding at a time. `pause_req` and `pause_val` hold steady until `pause_done`, and a pending frame waits for that pulse.
- R10: `backpressure` is high exactly when the block is in half-duplex mode, the enable is set, and either `reg_busy` or `fc_req` is high. It is always low in full-duplex mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half-duplex |
| wr_en | input | 1 | Register write strobe |
| wr_pause_time | input | 16 | Pause time to load |
| wr_thresh_sel | input | 2 | Resend threshold select to load |
| wr_zq_dis | input | 1 | Zero-quanta disable to load |
| wr_tx_fc_en | input | 1 | Transmit flow-control enable to load |
| wr_initiate | input | 1 | Initiate bit to load |
| reg_pause_time | output | 16 | Current pause time |
| reg_thresh_sel | output | 2 | Current threshold select |
| reg_zq_dis | output | 1 | Current zero-quanta disable |
| reg_tx_fc_en | output | 1 | Current flow-control enable |
| reg_busy | output | 1 | Initiate/busy bit |
| fc_req | input | 1 | External flow-control request level |
| slot_tick | input | 1 | One pulse per 512 bit times |
| pause_req | output | 1 | Pause frame request to the transmitter |
| pause_val | output | 16 | Pause value for the requested frame |
| pause_done | input | 1 | Transmitter reports the frame finished |
| backpressure | output | 1 | Half-duplex backpressure level |

## Verification
The hardest case to reach is the automatic resend. It needs a completed nonzero frame, a request still held, and an exact number of slot ticks after the done pulse. The bench starts with a rising request and completes that frame. It then sends ticks one at a time and leaves two idle cycles after each one. It records the tick count at which the new request first shows, and compares it with the pause time minus the selected offset for all four selects. One of those cases uses an offset larger than the pause time. A second hard case drops the request while a frame is outstanding, which checks that the zero pause waits for `pause_done`.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int PT_W  = 16;
    localparam int TH_W  = 2;
    localparam int OFF_W = 9;

    typedef struct packed {
        logic [PT_W-1:0] pt;
        logic [TH_W-1:0] sel;
        logic            zq;
        logic            tfe;
        logic            busy;
        logic            fc_q;
        logic            pend_on;
        logic            pend_zero;
        logic            req;
        logic [PT_W-1:0] val;
        logic            src_init;
        logic            active;
        logic [PT_W-1:0] cnt;
    } pctl_state_t;
endpackage

// File: rtl/pause_thresh_dec.sv
module pause_thresh_dec
    import pause_pkg::*;
#(
    parameter int OFF0 = 4,
    parameter int OFF1 = 28,
    parameter int OFF2 = 144,
    parameter int OFF3 = 256
) (
    input  logic [TH_W-1:0]  sel,
    output logic [OFF_W-1:0] offset
);
    always_comb begin
        case (sel)
            2'd0:    offset = OFF_W'(OFF0);
            2'd1:    offset = OFF_W'(OFF1);
            2'd2:    offset = OFF_W'(OFF2);
            default: offset = OFF_W'(OFF3);
        endcase
    end
endmodule

// File: rtl/pause_bp_gen.sv
module pause_bp_gen (
    input  logic full_duplex,
    input  logic tfe,
    input  logic busy,
    input  logic fc_req,
    output logic bp
);
    assign bp = !full_duplex && tfe && (busy || fc_req);
endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pause_pkg::*;
#(
    parameter int OFF0 = 4,
    parameter int OFF1 = 28,
    parameter int OFF2 = 144,
    parameter int OFF3 = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            full_duplex,
    input  logic            wr_en,
    input  logic [PT_W-1:0] wr_pause_time,
    input  logic [TH_W-1:0] wr_thresh_sel,
    input  logic            wr_zq_dis,
    input  logic            wr_tx_fc_en,
    input  logic            wr_initiate,
    output logic [PT_W-1:0] reg_pause_time,
    output logic [TH_W-1:0] reg_thresh_sel,
    output logic            reg_zq_dis,
    output logic            reg_tx_fc_en,
    output logic            reg_busy,
    input  logic            fc_req,
    input  logic            slot_tick,
    output logic            pause_req,
    output logic [PT_W-1:0] pause_val,
    input  logic            pause_done,
    output logic            backpressure
);
    localparam int SUM_W = PT_W + 1;

    pctl_state_t      q, d;
    logic [OFF_W-1:0] offset;
    logic             fd_on, rise, fall, write_ok, at_thresh;

    pause_thresh_dec #(
        .OFF0(OFF0), .OFF1(OFF1), .OFF2(OFF2), .OFF3(OFF3)
    ) u_dec (
        .sel    (q.sel),
        .offset (offset)
    );

    pause_bp_gen u_bp (
        .full_duplex (full_duplex),
        .tfe         (q.tfe),
        .busy        (q.busy),
        .fc_req      (fc_req),
        .bp          (backpressure)
    );

    always_comb begin
        d         = q;
        fd_on     = full_duplex && q.tfe;
        rise      = fc_req && !q.fc_q;
        fall      = !fc_req && q.fc_q;
        write_ok  = wr_en && !(full_duplex && q.busy);
        at_thresh = (SUM_W'(q.cnt) + SUM_W'(offset)) >= SUM_W'(q.pt);
        d.fc_q    = fc_req;

        // completion handshake
        if (q.req && pause_done) begin
            d.req = 1'b0;
            if (q.src_init) d.busy = 1'b0;
            d.active = (q.val != '0);
            d.cnt    = '0;
        end else begin
            // slot timer
            if (q.active && slot_tick) d.cnt = q.cnt + 1'b1;
            if (q.active && at_thresh) begin
                d.active = 1'b0;
                if (fd_on && q.fc_q && fc_req) d.pend_on = 1'b1;
            end
        end

        // request edges
        if (fd_on && rise) d.pend_on = 1'b1;
        if (fd_on && fall) begin
            d.pend_on   = 1'b0;
            d.active    = 1'b0;
            d.pend_zero = !q.zq;
        end
        if (!fd_on) begin
            d.pend_on   = 1'b0;
            d.pend_zero = 1'b0;
        end

        // issue one request when none is outstanding
        if (!q.req && fd_on) begin
            if (q.pend_zero) begin
                d.req = 1'b1; d.val = '0; d.src_init = 1'b0; d.pend_zero = 1'b0;
            end else if (q.pend_on) begin
                d.req = 1'b1; d.val = q.pt; d.src_init = 1'b0; d.pend_on = 1'b0;
            end else if (q.busy) begin
                d.req = 1'b1; d.val = q.pt; d.src_init = 1'b1;
            end
        end

        // initiate with frames disabled completes at once
        if (full_duplex && !q.tfe && q.busy) d.busy = 1'b0;

        // register write
        if (write_ok) begin
            d.pt   = wr_pause_time;
            d.sel  = wr_thresh_sel;
            d.zq   = wr_zq_dis;
            d.tfe  = wr_tx_fc_en;
            d.busy = wr_initiate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_pause_time = q.pt;
    assign reg_thresh_sel = q.sel;
    assign reg_zq_dis     = q.zq;
    assign reg_tx_fc_en   = q.tfe;
    assign reg_busy       = q.busy;
    assign pause_req      = q.req;
    assign pause_val      = q.val;
endmodule

// File: rtl/pause_tx_ctrl_chk.sv
module pause_tx_ctrl_chk
    import pause_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            full_duplex,
    input logic            wr_en,
    input logic [PT_W-1:0] reg_pause_time,
    input logic            reg_tx_fc_en,
    input logic            reg_busy,
    input logic            pause_req,
    input logic [PT_W-1:0] pause_val,
    input logic            pause_done,
    input logic            backpressure
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_done |=> pause_req && $stable(pause_val)); // R9
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_done |=> !pause_req); // R4
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex && reg_busy && wr_en |=> $stable(reg_pause_time)); // R3
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_tx_fc_en && !pause_req |=> !pause_req); // R5
    AST_NO_REQ_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !full_duplex && !pause_req |=> !pause_req); // R5
    AST_BP_FD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |-> !backpressure); // R10
endmodule

bind pause_tx_ctrl pause_tx_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .full_duplex    (full_duplex),
    .wr_en          (wr_en),
    .reg_pause_time (reg_pause_time),
    .reg_tx_fc_en   (reg_tx_fc_en),
    .reg_busy       (reg_busy),
    .pause_req      (pause_req),
    .pause_val      (pause_val),
    .pause_done     (pause_done),
    .backpressure   (backpressure)
);

// File: tb/sim_pause_tx_ctrl.sv
module sim_pause_tx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_duplex = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_pause_time = '0;
    logic [1:0]  wr_thresh_sel = '0;
    logic        wr_zq_dis = 1'b0, wr_tx_fc_en = 1'b0, wr_initiate = 1'b0;
    logic [15:0] reg_pause_time;
    logic [1:0]  reg_thresh_sel;
    logic        reg_zq_dis, reg_tx_fc_en, reg_busy;
    logic        fc_req = 1'b0, slot_tick = 1'b0, pause_done = 1'b0;
    logic        pause_req, backpressure;
    logic [15:0] pause_val;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_tx_ctrl u0 (.*);

    // {full_duplex, tfe, initiate, fc_req, expected backpressure}  R10
    localparam logic [4:0] BP_VEC [8] = '{
        5'b01000, 5'b01011, 5'b01101, 5'b01111,
        5'b00110, 5'b00010, 5'b11010, 5'b11100
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] pt, input logic [1:0] sel, input logic zq,
                      input logic tfe, input logic init);
        wr_pause_time = pt; wr_thresh_sel = sel; wr_zq_dis = zq;
        wr_tx_fc_en = tfe; wr_initiate = init; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        pause_done = 1'b1;
        cyc();
        pause_done = 1'b0;
    endtask

    task automatic drain();
        repeat (8) begin
            if (pause_req) pause_done = 1'b1;
            cyc();
            pause_done = 1'b0;
        end
    endtask

    task automatic resend_case(input logic [15:0] pt, input logic [1:0] sel, input int exp);
        int n;
        full_duplex = 1'b0; fc_req = 1'b0;
        wr(16'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        drain();
        full_duplex = 1'b1;
        wr(pt, sel, 1'b0, 1'b1, 1'b0);
        fc_req = 1'b1;
        cyc(2);
        chk(pause_req && pause_val == pt, "R6", pause_val, pt);
        done_pulse();
        n = 0;
        while (n < 400) begin
            cyc(2);
            if (pause_req) break;
            slot_tick = 1'b1; cyc(); slot_tick = 1'b0;
            n++;
        end
        chk(n == exp, "R7", n, exp);
        chk(pause_val == pt, "R7", pause_val, pt);
        done_pulse();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(2);
        // R1 reset state
        chk(reg_pause_time == 0 && reg_thresh_sel == 0 && !reg_zq_dis && !reg_tx_fc_en && !reg_busy,
            "R1", reg_pause_time, 0);
        chk(!pause_req && !backpressure, "R1", pause_req, 0);
        rst_n = 1'b1;
        cyc();

        // R10 table walk
        foreach (BP_VEC[i]) begin
            fc_req = 1'b0; full_duplex = 1'b0;
            wr(16'h10, 2'd0, 1'b1, 1'b0, 1'b0);
            drain();
            full_duplex = BP_VEC[i][4];
            wr(16'h10, 2'd0, 1'b1, BP_VEC[i][3], BP_VEC[i][2]);
            fc_req = BP_VEC[i][1];
            cyc();
            chk(backpressure == BP_VEC[i][0], "R10", backpressure, BP_VEC[i][0]);
            fc_req = 1'b0;
            drain();
        end

        // R2 write and readback in half duplex
        full_duplex = 1'b0;
        wr(16'hBEEF, 2'd2, 1'b1, 1'b0, 1'b0);
        chk(reg_pause_time == 16'hBEEF && reg_thresh_sel == 2 && reg_zq_dis && !reg_tx_fc_en,
            "R2", reg_pause_time, 16'hBEEF);
        // R5 half duplex with initiate: no frame
        wr(16'h0033, 2'd0, 1'b0, 1'b1, 1'b1);
        cyc(4);
        chk(!pause_req && reg_busy, "R5", pause_req, 0);
        // R2 half duplex write accepted while busy
        wr(16'h0044, 2'd1, 1'b0, 1'b1, 1'b0);
        chk(reg_pause_time == 16'h0044 && !reg_busy, "R2", reg_pause_time, 16'h0044);

        // R4 initiate in full duplex
        full_duplex = 1'b1;
        wr(16'h1234, 2'd0, 1'b0, 1'b1, 1'b1);
        chk(reg_busy && !pause_req, "R4", reg_busy, 1);
        cyc();
        chk(pause_req && pause_val == 16'h1234, "R4", pause_val, 16'h1234);
        // R3 write while busy ignored
        wr(16'h5555, 2'd3, 1'b1, 1'b0, 1'b0);
        chk(reg_pause_time == 16'h1234 && reg_thresh_sel == 0 && reg_tx_fc_en,
            "R3", reg_pause_time, 16'h1234);
        chk(pause_req && pause_val == 16'h1234, "R9", pause_val, 16'h1234);
        done_pulse();
        chk(!pause_req && !reg_busy, "R4", reg_busy, 0);
        cyc(3);
        chk(!pause_req, "R4", pause_req, 0);

        // R5 enable clear in full duplex
        wr(16'h0077, 2'd0, 1'b0, 1'b0, 1'b1);
        cyc();
        chk(!reg_busy, "R5", reg_busy, 0);
        fc_req = 1'b1;
        cyc(5);
        chk(!pause_req, "R5", pause_req, 0);
        fc_req = 1'b0;
        cyc(5);
        chk(!pause_req, "R5", pause_req, 0);

        // R7 all threshold selects
        resend_case(16'd40,  2'd0, 36);
        resend_case(16'd100, 2'd1, 72);
        resend_case(16'd200, 2'd2, 56);
        resend_case(16'd100, 2'd3, 0);

        // R8 zero pause on fall (fc still high from last case)
        fc_req = 1'b0;
        cyc(2);
        chk(pause_req && pause_val == 0, "R8", pause_val, 0);
        done_pulse();

        // R8 zero-quanta disabled
        wr(16'h0050, 2'd0, 1'b1, 1'b1, 1'b0);
        fc_req = 1'b1;
        cyc(2);
        chk(pause_req && pause_val == 16'h0050, "R6", pause_val, 16'h0050);
        done_pulse();
        fc_req = 1'b0;
        cyc(6);
        chk(!pause_req, "R8", pause_req, 0);

        // R9 fall while a frame is outstanding
        wr(16'h0060, 2'd0, 1'b0, 1'b1, 1'b0);
        fc_req = 1'b1;
        cyc(2);
        chk(pause_req && pause_val == 16'h0060, "R6", pause_val, 16'h0060);
        fc_req = 1'b0;
        cyc(4);
        chk(pause_req && pause_val == 16'h0060, "R9", pause_val, 16'h0060);
        done_pulse();
        chk(!pause_req, "R9", pause_req, 0);
        cyc();
        chk(pause_req && pause_val == 0, "R9", pause_val, 0);
        done_pulse();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule